// File: doc/BRIEF.md
# Collision-arbitrated dual-port RAM

This block is a single-clock memory with two read/write ports, A and B, of the same width. Each port has its own enable, write enable, address, write data and registered read data. When both ports reach the same word in the same cycle, the result is defined rather than left to chance. Two writes to that word are settled by a fixed priority. A read that meets a write on the other port returns either the old word or a forwarded copy of the new word, as a parameter selects. Any such meeting is reported on a one-cycle collision pulse and on a sticky flag.

Each port picks how its read data behaves on its own write cycles. Mode 0 returns the old word, mode 1 returns the word stored by that cycle, and mode 2 leaves the output register unchanged. Mode 2 suits a port that never needs read data while it writes. Depth is 2**ADDR_W words. The storage array has no reset. The output registers and the collision flags clear on a synchronous reset.

Top module: `twin_port_ram`

## Requirements
- R1: A read on an enabled port with its write enable low returns the word at its address on its read data output one clock after the request. Each port decodes its own address.
- R2: On its own write cycle, a port's read data follows its mode parameter: 0 returns the word held before the write, 1 returns the word stored at that address by that cycle, and 2 keeps the previous output.
- R3: A port with its enable low neither reads nor writes, whatever its write enable and data are, and its read data output keeps its value.
- R4: Two reads of the same address in one cycle both return the stored word and do not count as a collision.
- R5: When both ports write the same address in one cycle, only the priority port's data is stored. PRIORITY_A=1 gives port A priority and PRIORITY_A=0 gives port B priority.
- R6: A port in mode 1 that loses a write-write collision returns the winner's data, which is the word actually stored.
- R7: When one port writes and the other reads the same address in one cycle, the reader gets the old word if FWD_NEW=0 and the newly written data if FWD_NEW=1.
- R8: The collision output is high for exactly the one cycle after a cycle in which both ports were enabled on equal addresses and at least one was writing. It is low otherwise.
- R9: The collision-seen flag goes high together with the first collision pulse and stays high until reset.
- R10: A synchronous reset clears both read data outputs, the collision output and the collision-seen flag. Memory contents are kept through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| enA | input | 1 | Port A enable |
| weA | input | 1 | Port A write enable |
| addrA | input | ADDR_W | Port A word address |
| wdataA | input | DATA_W | Port A write data |
| rdataA | output | DATA_W | Port A registered read data |
| enB | input | 1 | Port B enable |
| weB | input | 1 | Port B write enable |
| addrB | input | ADDR_W | Port B word address |
| wdataB | input | DATA_W | Port B write data |
| rdataB | output | DATA_W | Port B registered read data |
| collision | output | 1 | One-cycle pulse for a same-address conflict |
| collisionSeen | output | 1 | Sticky record that a conflict has occurred |

## Verification
Every result of this block is due exactly one clock after the cycle that caused it. This holds for both read data outputs, the collision pulse and the sticky flag, and a write shows up in a later read of that address. The bench applies each request at a falling edge. A behavioural model then computes what the rising edge will produce, and the bench compares at the next falling edge, so every comparison sits one register stage after its stimulus. Words the model has never seen written are marked unknown and are not compared. This lets the read-old mode run on fresh addresses without false failures.

// File: rtl/tpr_pkg.sv
package tpr_pkg;

  // read-data behaviour of a port during its own write cycle
  typedef enum logic [1:0] {
    RD_OLD  = 2'd0,
    RD_NEW  = 2'd1,
    RD_KEEP = 2'd2
  } rd_mode_e;

  // per-port strobes, index 0 = port A, index 1 = port B
  typedef struct packed {
    logic [1:0] wr;    // commit the port's write data to the array
    logic [1:0] upd;   // load the port's output register
    logic [1:0] fwd;   // load forwarded write data instead of array data
    logic [1:0] srcB;  // forwarded data comes from port B (else port A)
  } strobe_t;

endpackage

// File: rtl/tpr_ctrl.sv
module tpr_ctrl
  import tpr_pkg::*;
#(
  parameter int       ADDR_W     = 11,
  parameter rd_mode_e MODE_A     = RD_OLD,
  parameter rd_mode_e MODE_B     = RD_OLD,
  parameter bit       PRIORITY_A = 1'b1,
  parameter bit       FWD_NEW    = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enA,
  input  logic              weA,
  input  logic [ADDR_W-1:0] addrA,
  input  logic              enB,
  input  logic              weB,
  input  logic [ADDR_W-1:0] addrB,
  output strobe_t           st,
  output logic              collision,
  output logic              collisionSeen
);

  logic [1:0] enV;
  logic [1:0] wrReq;
  logic       sameAddr;
  logic       bothWr;
  logic       clash;

  function automatic rd_mode_e portMode(input int p);
    return (p == 0) ? MODE_A : MODE_B;
  endfunction

  always_comb begin
    enV      = {enB, enA};
    wrReq    = {enB && weB, enA && weA};
    sameAddr = enA && enB && (addrA == addrB);
    bothWr   = sameAddr && wrReq[0] && wrReq[1];
    clash    = sameAddr && (wrReq != 2'b00);

    st.wr[0] = wrReq[0] && !(bothWr && !PRIORITY_A);
    st.wr[1] = wrReq[1] && !(bothWr && PRIORITY_A);

    for (int p = 0; p < 2; p++) begin
      st.upd[p]  = 1'b0;
      st.fwd[p]  = 1'b0;
      st.srcB[p] = (p == 1);
      if (enV[p]) begin
        if (wrReq[p]) begin
          unique case (portMode(p))
            RD_OLD: st.upd[p] = 1'b1;
            RD_NEW: begin
              st.upd[p]  = 1'b1;
              st.fwd[p]  = 1'b1;
              // a losing port reflects the winner's stored word
              st.srcB[p] = st.wr[p] ? (p == 1) : (p == 0);
            end
            default: st.upd[p] = 1'b0;
          endcase
        end else begin
          st.upd[p] = 1'b1;
          if (sameAddr && wrReq[1-p]) begin
            st.fwd[p]  = FWD_NEW;
            st.srcB[p] = (p == 0);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      collision     <= 1'b0;
      collisionSeen <= 1'b0;
    end else begin
      collision     <= clash;
      collisionSeen <= collisionSeen || clash;
    end
  end

  // R8
  pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    collision |-> ($past(enA) && $past(enB) && ($past(addrA) == $past(addrB))));

  // R8
  quiet_reads_chk: assert property (@(posedge clk) disable iff (rst)
    (!weA && !weB) |=> !collision);

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    collisionSeen |=> collisionSeen);

  // R9
  sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
    collision |-> collisionSeen);

endmodule

// File: rtl/tpr_datapath.sv
module tpr_datapath
  import tpr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           st,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [DATA_W-1:0] wdataA,
  input  logic [DATA_W-1:0] wdataB,
  output logic [DATA_W-1:0] rdataA,
  output logic [DATA_W-1:0] rdataB
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrV [2];
  logic [DATA_W-1:0] rdataV [2];

  assign addrV[0] = addrA;
  assign addrV[1] = addrB;
  assign rdataA   = rdataV[0];
  assign rdataB   = rdataV[1];

  // the controller never lets both ports commit to one address
  always_ff @(posedge clk) begin
    if (st.wr[0]) mem[addrA] <= wdataA;
    if (st.wr[1]) mem[addrB] <= wdataB;
  end

  for (genvar p = 0; p < 2; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        rdataV[p] <= '0;
      end else if (st.upd[p]) begin
        if (st.fwd[p]) rdataV[p] <= st.srcB[p] ? wdataB : wdataA;
        else           rdataV[p] <= mem[addrV[p]];
      end
    end
  end

  // R5
  single_writer_chk: assert property (@(posedge clk) disable iff (rst)
    !(st.wr[0] && st.wr[1] && (addrA == addrB)));

endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram
  import tpr_pkg::*;
#(
  parameter int       DATA_W     = 9,
  parameter int       ADDR_W     = 11,
  parameter rd_mode_e MODE_A     = RD_OLD,
  parameter rd_mode_e MODE_B     = RD_OLD,
  parameter bit       PRIORITY_A = 1'b1,
  parameter bit       FWD_NEW    = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enA,
  input  logic              weA,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [DATA_W-1:0] wdataA,
  output logic [DATA_W-1:0] rdataA,
  input  logic              enB,
  input  logic              weB,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [DATA_W-1:0] wdataB,
  output logic [DATA_W-1:0] rdataB,
  output logic              collision,
  output logic              collisionSeen
);

  strobe_t st;

  tpr_ctrl #(
    .ADDR_W(ADDR_W), .MODE_A(MODE_A), .MODE_B(MODE_B),
    .PRIORITY_A(PRIORITY_A), .FWD_NEW(FWD_NEW)
  ) i_ctrl (
    .clk(clk), .rst(rst),
    .enA(enA), .weA(weA), .addrA(addrA),
    .enB(enB), .weB(weB), .addrB(addrB),
    .st(st), .collision(collision), .collisionSeen(collisionSeen)
  );

  tpr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rst(rst), .st(st),
    .addrA(addrA), .addrB(addrB),
    .wdataA(wdataA), .wdataB(wdataB),
    .rdataA(rdataA), .rdataB(rdataB)
  );

  // R3
  idle_a_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !enA |=> $stable(rdataA));

  // R3
  idle_b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !enB |=> $stable(rdataB));

  if (MODE_A == RD_KEEP) begin : g_keep_a
    // R2
    keep_a_chk: assert property (@(posedge clk) disable iff (rst)
      (enA && weA) |=> $stable(rdataA));
  end
  if (MODE_B == RD_KEEP) begin : g_keep_b
    // R2
    keep_b_chk: assert property (@(posedge clk) disable iff (rst)
      (enB && weB) |=> $stable(rdataB));
  end

endmodule

// File: tb/test_twin_port_ram.sv
`timescale 1ns/1ps
module test_twin_port_ram;
  import tpr_pkg::*;

  localparam int DW = 9;
  localparam int AW = 11;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enA = 0, weA = 0, enB = 0, weB = 0;
  logic [AW-1:0] addrA = '0, addrB = '0;
  logic [DW-1:0] wdataA = '0, wdataB = '0;
  logic [DW-1:0] rdA1, rdB1, rdA2, rdB2;
  logic col1, seen1, col2, seen2;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state: -1 marks an unknown word
  int mem1 [NW];
  int mem2 [NW];
  int eA1, eB1, eC1, eS1;
  int eA2, eB2, eC2, eS2;

  always #10 clk = ~clk;

  // config 1: A read-old, B write-new, A wins, reader sees old word
  twin_port_ram #(.DATA_W(DW), .ADDR_W(AW), .MODE_A(RD_OLD), .MODE_B(RD_NEW),
                  .PRIORITY_A(1'b1), .FWD_NEW(1'b0)) i_twin_port_ram (
    .clk(clk), .rst(rst),
    .enA(enA), .weA(weA), .addrA(addrA), .wdataA(wdataA), .rdataA(rdA1),
    .enB(enB), .weB(weB), .addrB(addrB), .wdataB(wdataB), .rdataB(rdB1),
    .collision(col1), .collisionSeen(seen1));

  // config 2: A write-new, B keep, B wins, reader sees forwarded word
  twin_port_ram #(.DATA_W(DW), .ADDR_W(AW), .MODE_A(RD_NEW), .MODE_B(RD_KEEP),
                  .PRIORITY_A(1'b0), .FWD_NEW(1'b1)) i_twin_port_ram_alt (
    .clk(clk), .rst(rst),
    .enA(enA), .weA(weA), .addrA(addrA), .wdataA(wdataA), .rdataA(rdA2),
    .enB(enB), .weB(weB), .addrB(addrB), .wdataB(wdataB), .rdataB(rdB2),
    .collision(col2), .collisionSeen(seen2));

  function automatic int portOut(bit en, bit we, int mode, int oldv, int fin,
                                 bit otherHits, bit fwdNew, int prev);
    if (!en) return prev;
    if (we) begin
      if (mode == 0) return oldv;
      if (mode == 1) return fin;
      return prev;
    end
    if (otherHits && fwdNew) return fin;
    return oldv;
  endfunction

  task automatic modelStep(input int modeA, input int modeB, input bit prioA,
                           input bit fwdNew, ref int mem [NW],
                           ref int expA, ref int expB, ref int expC, ref int expS);
    int  a, b, oldA, oldB, finA, finB;
    bit  same, wA, wB, keepA, keepB, hit;
    a = int'(addrA); b = int'(addrB);
    oldA = mem[a]; oldB = mem[b];
    same = enA && enB && (a == b);
    wA = enA && weA; wB = enB && weB;
    keepA = wA && !(same && wB && !prioA);
    keepB = wB && !(same && wA && prioA);
    finA = keepA ? int'(wdataA) : ((keepB && b == a) ? int'(wdataB) : oldA);
    finB = keepB ? int'(wdataB) : ((keepA && a == b) ? int'(wdataA) : oldB);
    expA = portOut(enA, weA, modeA, oldA, finA, same && wB, fwdNew, expA);
    expB = portOut(enB, weB, modeB, oldB, finB, same && wA, fwdNew, expB);
    hit  = same && (wA || wB);
    expC = hit ? 1 : 0;
    if (hit) expS = 1;
    if (keepA) mem[a] = int'(wdataA);
    if (keepB) mem[b] = int'(wdataB);
  endtask

  task automatic checkVal(string tag, string what, int actual, int expv);
    if (expv < 0) return;
    checks++;
    if (actual != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, actual, expv, $time);
    end
  endtask

  task automatic compareAll(string tag);
    checkVal(tag, "cfg1 rdataA", int'(rdA1), eA1);
    checkVal(tag, "cfg1 rdataB", int'(rdB1), eB1);
    checkVal(tag, "cfg2 rdataA", int'(rdA2), eA2);
    checkVal(tag, "cfg2 rdataB", int'(rdB2), eB2);
    checkVal("R8", "cfg1 collision", int'(col1), eC1);
    checkVal("R8", "cfg2 collision", int'(col2), eC2);
    checkVal("R9", "cfg1 collisionSeen", int'(seen1), eS1);
    checkVal("R9", "cfg2 collisionSeen", int'(seen2), eS2);
  endtask

  // drive at a falling edge, check one clock later at the next falling edge
  task automatic doCycle(string tag, bit ea, bit wa, int aa, int da,
                         bit eb, bit wb, int ab, int db);
    enA = ea; weA = wa; addrA = AW'(aa); wdataA = DW'(da);
    enB = eb; weB = wb; addrB = AW'(ab); wdataB = DW'(db);
    modelStep(0, 1, 1'b1, 1'b0, mem1, eA1, eB1, eC1, eS1);
    modelStep(1, 2, 1'b0, 1'b1, mem2, eA2, eB2, eC2, eS2);
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic doReset();
    enA = 0; enB = 0; weA = 0; weB = 0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    eA1 = 0; eB1 = 0; eC1 = 0; eS1 = 0;
    eA2 = 0; eB2 = 0; eC2 = 0; eS2 = 0;
    // R10: outputs and flags cleared
    compareAll("R10");
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin mem1[i] = -1; mem2[i] = -1; end
    @(negedge clk);
    doReset();
    // R1: independent writes, then crossed reads
    doCycle("R1", 1, 1, 5, 'h0A5, 1, 1, 6, 'h1B6);
    doCycle("R1", 1, 0, 6, 0, 1, 0, 5, 0);
    // R4: same-address reads, no collision
    doCycle("R4", 1, 0, 5, 0, 1, 0, 5, 0);
    // R2 mode on own write; R3 disabled B with write enable set is ignored
    doCycle("R2", 1, 1, 5, 'h033, 0, 1, 5, 'h1EE);
    doCycle("R3", 0, 1, 5, 'h111, 1, 0, 5, 0);
    doCycle("R2", 0, 0, 0, 0, 1, 1, 7, 'h155);
    doCycle("R1", 1, 1, 9, 'h001, 0, 0, 0, 0);
    // R5/R6: write-write on one address
    doCycle("R6", 1, 1, 9, 'h0F0, 1, 1, 9, 'h10F);
    doCycle("R5", 1, 0, 9, 0, 1, 0, 9, 0);
    // R7: write on A against read on B, then the reverse
    doCycle("R7", 1, 1, 9, 'h0AA, 1, 0, 9, 0);
    doCycle("R7", 1, 0, 9, 0, 1, 1, 9, 'h077);
    // R1: address extremes
    doCycle("R1", 1, 1, NW-1, 'h1FF, 1, 1, 0, 'h100);
    doCycle("R1", 1, 0, 0, 0, 1, 0, NW-1, 0);
    // R3: both idle, outputs hold
    doCycle("R3", 0, 1, 3, 'h055, 0, 1, 3, 'h0CC);
    doCycle("R3", 1, 0, 3, 0, 1, 0, 9, 0);
    // R10: reset clears outputs, memory survives
    doReset();
    doCycle("R10", 1, 0, 9, 0, 1, 0, 7, 0);
    doCycle("R10", 1, 0, NW-1, 0, 1, 0, 5, 0);
    // mixed traffic over a few addresses to provoke every kind of clash
    for (int n = 0; n < 400; n++) begin
      doCycle("R7", ($urandom % 4) != 0, $urandom % 2, $urandom % 4, $urandom % 512,
                    ($urandom % 4) != 0, $urandom % 2, $urandom % 4, $urandom % 512);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule